// File: doc/BRIEF.md
# Dual-Clock Field FIFO Pointer Controller

This block runs the write and read sides of a large field-style FIFO whose two ports sit on unrelated clocks. The write side takes a byte on each rising write-clock edge and keeps a write pointer. The read side presents a byte on each rising read-clock edge and keeps a read pointer. A write mask lets the write pointer step over a location and leave its contents alone. A read skip lets the read pointer step past a location while the output pads stay undriven. Each side has its own pointer clear. The write side raises a space flag and the read side raises a data flag. The flags are derived from Gray-coded pointers that cross into the other clock domain through two-flop synchronisers.

The pointers follow their enables and do not look at the flags. The system around the block uses the flags to pace the traffic, which is how a field memory behaves. One static select input sets the active level of the six control inputs and the two flags together. It is changed only while the global reset is held. The storage is a behavioural dual-clock RAM inside the block. `DEPTH` must be a power of two.

Top module: `fifo_fld_ctrl`

## Requirements
- R1: While `rst_ni` is low, both pointers are zero, the pad enable `rd_oe_o` is low, the data flag is inactive and the space flag is active. The read data register reads 0.
- R2: On a rising `clk_w_i` edge with write enable active and write clear inactive, the byte on `wr_data_i` is stored at the write pointer when input-keep is active, and the write pointer advances by one.
- R3: On a write edge with write enable active and input-keep inactive, the write pointer still advances by one, and the location keeps its earlier contents.
- R4: On a rising `clk_r_i` edge with read enable active and read clear inactive, `rd_data_o` takes the byte at the read pointer and the read pointer advances by one. With read enable inactive, `rd_data_o` holds.
- R5: On every read-clock edge, `rd_oe_o` takes the active state of the output-show input. A read with show inactive still advances the read pointer.
- R6: An active write clear sets the write pointer to 0 at the next write edge and overrides write enable, so nothing is stored on that edge. An active read clear does the same on the read side, and the read data does not change.
- R7: When `pol_low_i` = 1, the inputs `wr_en_i`, `wr_keep_i`, `wr_clr_i`, `rd_en_i`, `rd_show_i` and `rd_clr_i` are active at 0, and so are the flags `wr_space_o` and `rd_avail_o`. When `pol_low_i` = 0, all eight are active at 1.
- R8: The data flag goes active no later than the third read-clock edge after a write makes the FIFO non-empty. It goes inactive right after the read edge that empties the FIFO.
- R9: The space flag goes inactive right after the write edge that leaves DEPTH unread entries. It goes active again no later than the third write-clock edge after a read frees an entry.
- R10: Pointers wrap modulo DEPTH, so data written across the wrap is read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w_i | input | 1 | Write clock |
| clk_r_i | input | 1 | Read clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| pol_low_i | input | 1 | Polarity select: 1 = active-low controls and flags |
| wr_en_i | input | 1 | Write enable, advances the write pointer |
| wr_keep_i | input | 1 | Input-keep: store the byte (inactive = write mask) |
| wr_clr_i | input | 1 | Write pointer clear |
| wr_data_i | input | DW | Write data |
| wr_space_o | output | 1 | Space available flag |
| rd_en_i | input | 1 | Read enable, advances the read pointer |
| rd_show_i | input | 1 | Output-show: drive the pads (inactive = read skip) |
| rd_clr_i | input | 1 | Read pointer clear |
| rd_data_o | output | DW | Read data |
| rd_oe_o | output | 1 | Pad drive enable for `rd_data_o` |
| rd_avail_o | output | 1 | Data available flag |

## Verification
The bench builds the block with DEPTH = 16 and DW = 8. A depth that small lets a short run fill the FIFO so the space flag drops, drain it so the data flag drops, and carry the pointers across the wrap. The whole sequence runs once with `pol_low_i` at 0 and once at 1, with a global reset between the two passes. Masked writes and pointer clears are placed over locations whose old contents are known, so the data read back shows that those locations were left alone.

// File: rtl/fifo_fld_pkg.sv
package fifo_fld_pkg;

  // Control group of one port after polarity has been resolved
  typedef struct packed {
    logic adv;
    logic keep;
    logic clr;
  } port_ctl_t;

endpackage

// File: rtl/fld_ptr.sv
module fld_ptr #(
  parameter int AW = 10,
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_q, gray_q, bin_d;

  always_comb begin
    bin_d = bin_q;
    if (clr_i)      bin_d = '0;
    else if (adv_i) bin_d = bin_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
    end
  end

  assign bin_o  = bin_q;
  assign gray_o = gray_q;
endmodule

// File: rtl/fld_sync.sv
module fld_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fld_g2b.sv
module fld_g2b #(
  parameter int W = 11
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/fld_ram.sv
module fld_ram #(
  parameter int DW = 8,
  parameter int AW = 10,
  localparam int N = 1 << AW
) (
  input  logic          clk_w_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk_w_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fifo_fld_ctrl.sv
module fifo_fld_ctrl
  import fifo_fld_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_w_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          pol_low_i,
  input  logic          wr_en_i,
  input  logic          wr_keep_i,
  input  logic          wr_clr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_space_o,
  input  logic          rd_en_i,
  input  logic          rd_show_i,
  input  logic          rd_clr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o,
  output logic          rd_avail_o
);
  localparam logic [PW-1:0] FULL_DIFF = PW'(DEPTH);

  port_ctl_t wr_c, rd_c;
  logic      wr_step, rd_step;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_s, rgray_s, wbin_s, rbin_s;
  logic          oe_q;

  // polarity resolution: pol_low_i=1 means pins are active low
  assign wr_c = '{adv: wr_en_i ^ pol_low_i, keep: wr_keep_i ^ pol_low_i, clr: wr_clr_i ^ pol_low_i};
  assign rd_c = '{adv: rd_en_i ^ pol_low_i, keep: rd_show_i ^ pol_low_i, clr: rd_clr_i ^ pol_low_i};

  assign wr_step = wr_c.adv & ~wr_c.clr;
  assign rd_step = rd_c.adv & ~rd_c.clr;

  fld_ptr #(.AW(AW)) i_wptr (
    .clk_i(clk_w_i), .rst_ni(rst_ni), .clr_i(wr_c.clr), .adv_i(wr_step),
    .bin_o(wptr_bin), .gray_o(wptr_gray)
  );

  fld_ptr #(.AW(AW)) i_rptr (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .clr_i(rd_c.clr), .adv_i(rd_step),
    .bin_o(rptr_bin), .gray_o(rptr_gray)
  );

  fld_sync #(.W(PW), .STAGES(2)) i_w2r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(wptr_gray), .q_o(wgray_s)
  );

  fld_sync #(.W(PW), .STAGES(2)) i_r2w (
    .clk_i(clk_w_i), .rst_ni(rst_ni), .d_i(rptr_gray), .q_o(rgray_s)
  );

  fld_g2b #(.W(PW)) i_wg2b (.gray_i(wgray_s), .bin_o(wbin_s));
  fld_g2b #(.W(PW)) i_rg2b (.gray_i(rgray_s), .bin_o(rbin_s));

  fld_ram #(.DW(DW), .AW(AW)) i_ram (
    .clk_w_i(clk_w_i), .we_i(wr_step & wr_c.keep), .waddr_i(wptr_bin[AW-1:0]),
    .wdata_i(wr_data_i),
    .clk_r_i(clk_r_i), .rst_ni(rst_ni), .re_i(rd_step), .raddr_i(rptr_bin[AW-1:0]),
    .rdata_o(rd_data_o)
  );

  // pad enable follows the show input sampled on every read edge
  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= rd_c.keep;
  end
  assign rd_oe_o = oe_q;

  assign wr_space_o = ((wptr_bin - rbin_s) != FULL_DIFF) ^ pol_low_i;
  assign rd_avail_o = (wbin_s != rptr_bin) ^ pol_low_i;
endmodule

// File: rtl/fld_chk.sv
module fld_chk #(
  parameter int AW = 10,
  localparam int PW = AW + 1
) (
  input logic          clk_w_i,
  input logic          clk_r_i,
  input logic          rst_ni,
  input logic          pol_low_i,
  input logic          wr_en_i,
  input logic          wr_keep_i,
  input logic          wr_clr_i,
  input logic          rd_en_i,
  input logic          rd_show_i,
  input logic          rd_clr_i,
  input logic          rd_oe_o,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  // R1
  always @(posedge clk_r_i) begin
    if (!rst_ni) reset_state_chk: assert (rptr == '0 && !rd_oe_o);
  end

  // R2
  wr_advance_chk: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    ((wr_en_i ^ pol_low_i) && !(wr_clr_i ^ pol_low_i)) |=> (wptr == PW'($past(wptr) + 1'b1)));

  // R3
  wr_mask_step_chk: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    ((wr_en_i ^ pol_low_i) && !(wr_keep_i ^ pol_low_i) && !(wr_clr_i ^ pol_low_i))
      |=> (wptr == PW'($past(wptr) + 1'b1)));

  // R4
  rd_advance_chk: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    ((rd_en_i ^ pol_low_i) && !(rd_clr_i ^ pol_low_i)) |=> (rptr == PW'($past(rptr) + 1'b1)));

  // R5
  rd_skip_chk: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    !(rd_show_i ^ pol_low_i) |=> !rd_oe_o);

  // R6
  wr_clear_chk: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    (wr_clr_i ^ pol_low_i) |=> (wptr == '0));

  // R6
  rd_clear_chk: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_clr_i ^ pol_low_i) |=> (rptr == '0));
endmodule

bind fifo_fld_ctrl fld_chk #(.AW(AW)) i_fld_chk (
  .clk_w_i(clk_w_i), .clk_r_i(clk_r_i), .rst_ni(rst_ni), .pol_low_i(pol_low_i),
  .wr_en_i(wr_en_i), .wr_keep_i(wr_keep_i), .wr_clr_i(wr_clr_i),
  .rd_en_i(rd_en_i), .rd_show_i(rd_show_i), .rd_clr_i(rd_clr_i),
  .rd_oe_o(rd_oe_o), .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/test_fifo_fld_ctrl.sv
module test_fifo_fld_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 16;
  localparam int DW         = 8;

  logic clk_w = 1'b0, clk_r = 1'b0, rst_n = 1'b0, pol = 1'b0;
  logic wr_en, wr_keep, wr_clr, rd_en, rd_show, rd_clr;
  logic [DW-1:0] wr_data, rd_data;
  logic wr_space, rd_oe, rd_avail;

  always #(CLK_PERIOD/2) clk_w = ~clk_w;
  always #(RD_PERIOD/2)  clk_r = ~clk_r;

  fifo_fld_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_fifo_fld_ctrl (
    .clk_w_i(clk_w), .clk_r_i(clk_r), .rst_ni(rst_n), .pol_low_i(pol),
    .wr_en_i(wr_en), .wr_keep_i(wr_keep), .wr_clr_i(wr_clr), .wr_data_i(wr_data),
    .wr_space_o(wr_space),
    .rd_en_i(rd_en), .rd_show_i(rd_show), .rd_clr_i(rd_clr),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe), .rd_avail_o(rd_avail)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] mem_m [DEPTH];
  int wp = 0, rp = 0;
  logic exp_oe = 1'b0;
  logic [DW-1:0] exp_dat = '0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    wr_en = pol; wr_keep = pol; wr_clr = pol;
    rd_en = pol; rd_show = pol; rd_clr = pol;
  endtask

  task automatic wr(bit en, bit keep, bit clr, int d);
    @(negedge clk_w);
    wr_en = en ^ pol; wr_keep = keep ^ pol; wr_clr = clr ^ pol; wr_data = DW'(d);
    @(posedge clk_w);
    if (clr) wp = 0;
    else if (en) begin
      if (keep) mem_m[wp % DEPTH] = DW'(d);
      wp = (wp + 1) % (2*DEPTH);
    end
    #1;
    wr_en = pol; wr_keep = pol; wr_clr = pol;
  endtask

  task automatic rd(bit en, bit show, bit clr, string req);
    @(negedge clk_r);
    rd_en = en ^ pol; rd_show = show ^ pol; rd_clr = clr ^ pol;
    @(posedge clk_r);
    if (clr) rp = 0;
    else if (en) begin
      exp_dat = mem_m[rp % DEPTH];
      rp = (rp + 1) % (2*DEPTH);
    end
    exp_oe = show;
    #1;
    rd_en = pol; rd_clr = pol;
    #(RD_PERIOD/4);
    check(rd_oe == exp_oe, req, int'(rd_oe), int'(exp_oe));
    if (exp_oe) check(rd_data == exp_dat, req, int'(rd_data), int'(exp_dat));
  endtask

  task automatic flags(string req);
    int items = (wp - rp + 2*DEPTH) % (2*DEPTH);
    check((rd_avail ^ pol) == (items != 0), req, int'(rd_avail ^ pol), int'(items != 0));
    check((wr_space ^ pol) == (items != DEPTH), req, int'(wr_space ^ pol), int'(items != DEPTH));
  endtask

  task automatic run_pass();
    rst_n = 1'b0;
    idle_pins();
    wp = 0; rp = 0; exp_oe = 1'b0; exp_dat = '0;
    repeat (3) @(posedge clk_r);
    #1;
    // R1 R7: reset state under the selected polarity
    check(rd_oe == 1'b0, "R1", int'(rd_oe), 0);
    check(rd_data == '0, "R1", int'(rd_data), 0);
    check((rd_avail ^ pol) == 1'b0, "R7", int'(rd_avail), int'(pol));
    check((wr_space ^ pol) == 1'b1, "R7", int'(wr_space), int'(!pol));
    @(negedge clk_w);
    rst_n = 1'b1;
    // R8: one write raises the data flag within three read edges
    wr(1, 1, 0, 8'hA5);
    repeat (3) @(posedge clk_r);
    #1 flags("R8");
    // R2 R9: fill to DEPTH, space drops at once
    for (int i = 1; i < DEPTH; i++) wr(1, 1, 0, 8'h10 + i);
    #1 flags("R9");
    // R4: first read, then space returns within three write edges
    rd(1, 1, 0, "R4");
    repeat (3) @(posedge clk_w);
    #1 flags("R9");
    // R5: read skip on every third read
    for (int i = 1; i < DEPTH; i++) rd(1, (i % 3) != 1, 0, "R5");
    #1 flags("R8");
    rd(0, 1, 0, "R4");
    // R10: data across the pointer wrap
    for (int i = 0; i < 10; i++) wr(1, 1, 0, 8'h50 + i);
    for (int i = 0; i < 10; i++) rd(1, 1, 0, "R10");
    repeat (4) @(posedge clk_w);
    #1 flags("R10");
    // R3: masked writes leave old contents in place
    wr(0, 0, 1, 0);
    rd(0, 1, 1, "R6");
    for (int i = 0; i < 6; i++) wr(1, (i % 2) == 0, 0, 8'hC0 + i);
    for (int i = 0; i < 6; i++) rd(1, 1, 0, "R3");
    // R6: clears override enables and store nothing
    for (int i = 0; i < 4; i++) wr(1, 1, 0, 8'h70 + i);
    wr(1, 1, 1, 8'hEE);
    for (int i = 0; i < 2; i++) wr(1, 1, 0, 8'h90 + i);
    rd(1, 1, 1, "R6");
    for (int i = 0; i < 10; i++) rd(1, 1, 0, "R6");
  endtask

  initial begin
    idle_pins();
    wr_data = '0;
    pol = 1'b0;
    run_pass();
    pol = 1'b1;
    run_pass();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule